// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects a bank of level-sensitive hardware interrupt lines and hands the most urgent one to a single CPU. Every line carries one mask bit and one software-trigger bit. The software bit is ORed with the hardware level to form the effective request. Among effective requests that are not masked, the line with the lowest number always takes precedence. A single interrupt output tells the CPU that some unmasked request exists.

The CPU learns which line to service through a dedicated event read port. Each read strobe returns the winning line and, in the same cycle, sets that line's mask bit. The line then stays silent until software unmasks it again. A read that finds nothing pending returns zero and changes no state. A small configuration bus sets and clears the mask and software-trigger bits through write-one-to-act registers, 32 lines per word. The event port is separate from the configuration bus, so a mask write and an event delivery can land in the same cycle. When that happens both take effect.

Top module: `irq_arbiter_ctrl`

## Requirements
- R1: A hardware input counts as a request only while it is high. A line whose input has dropped before the event read is not delivered.
- R2: A masked line is never returned by an event read and never raises `irq_out`.
- R3: The effective request of a line is its hardware input ORed with its software-trigger bit. A software trigger alone is delivered like a hardware request.
- R4: Among unmasked effective requests, the lowest line number is delivered first.
- R5: An event read returns type 1 in bits [31:16] and the line number in bits [15:0]. It returns all zeros when nothing is pending. `evt_data` is registered: it updates on the edge that samples `evt_rd` and holds its value while `evt_rd` is low.
- R6: Delivering line n through an event read sets mask bit n on the same edge. The read leaves the software-trigger bit of line n unchanged.
- R7: `irq_out` is registered. On every edge it takes the OR of all unmasked effective requests, using the mask and trigger state held before that edge.
- R8: An event read that finds no unmasked effective request returns 0 and changes neither the masks nor the software triggers.
- R9: Address bits [7:4] select the region and bits [3:0] select a 32-line word. The regions are: 1 = set mask, 2 = clear mask, 3 = set trigger, 4 = clear trigger. Only the 1 bits of a write act. Reads of regions 1 and 2 return the mask word, reads of regions 3 and 4 return the trigger word, and any other address reads 0. Write data to an unused address is ignored. Read data appears after the edge that samples the read.
- R10: Suppose a clear-mask write and a delivering event read land on the same edge. The delivered line ends up masked, even if the write clears it. Every other bit of the write still takes effect.
- R11: Reset leaves every line masked, every software trigger cleared, `irq_out` low and `evt_data` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_hw | input | NUM_LINES | Level-sensitive hardware interrupt inputs |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Region in [7:4], word index in [3:0] |
| cfg_wdata | input | DATA_W | Write data, one bit per line |
| cfg_rdata | output | DATA_W | Registered read data |
| evt_rd | input | 1 | Event read strobe: deliver and acknowledge |
| evt_data | output | DATA_W | Registered event value |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The results fall due at different times:
- An event read sampled on an edge has its value on `evt_data` and its auto-mask in the mask state right after that edge.
- A configuration write changes the mask or trigger state on its edge. `irq_out` follows on the next edge.
- A change on `irq_hw` shows on `irq_out` after one edge.
- Configuration reads return data after the edge that samples them.

The bench drives every input on the falling edge and samples on the next falling edge. Each task waits exactly one rising edge for a register result. For `irq_out` it waits a further rising edge after any state change, so every comparison is made against the model state that the design saw on the edge in question.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REGION_W    = 4;
    localparam int WORD_IDX_W  = 4;
    localparam int EVT_TYPE_HW = 1;

    typedef enum logic [REGION_W-1:0] {
        RG_NONE = 4'd0,
        RG_MSET = 4'd1,
        RG_MCLR = 4'd2,
        RG_SSET = 4'd3,
        RG_SCLR = 4'd4
    } region_e;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_line_bank.sv
module irqc_line_bank
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    localparam int NUM_WORDS = NUM_LINES / DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic                 cfg_write,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [NUM_LINES-1:0] auto_set,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] sw_q,
    output logic [DATA_W-1:0]    cfg_rdata
);
    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] sw;
        logic [DATA_W-1:0]    rdata;
    } bank_t;

    bank_t state_d, state_q;

    logic [REGION_W-1:0]   region;
    logic [WORD_IDX_W-1:0] word_idx;
    logic [NUM_LINES-1:0]  set_m, clr_m, set_s, clr_s;
    logic [DATA_W-1:0]     rd_word;

    assign region   = cfg_addr[ADDR_W-1 -: REGION_W];
    assign word_idx = cfg_addr[WORD_IDX_W-1:0];

    always_comb begin
        set_m   = '0;
        clr_m   = '0;
        set_s   = '0;
        clr_s   = '0;
        rd_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_idx == WORD_IDX_W'(w)) begin
                if (cfg_valid && cfg_write) begin
                    case (region)
                        RG_MSET: set_m[w*DATA_W +: DATA_W] = cfg_wdata;
                        RG_MCLR: clr_m[w*DATA_W +: DATA_W] = cfg_wdata;
                        RG_SSET: set_s[w*DATA_W +: DATA_W] = cfg_wdata;
                        RG_SCLR: clr_s[w*DATA_W +: DATA_W] = cfg_wdata;
                        default: ;
                    endcase
                end
                case (region)
                    RG_MSET, RG_MCLR: rd_word = state_q.mask[w*DATA_W +: DATA_W];
                    RG_SSET, RG_SCLR: rd_word = state_q.sw[w*DATA_W +: DATA_W];
                    default:          rd_word = '0;
                endcase
            end
        end

        state_d = state_q;
        // The auto-mask is ORed in last: it can only set a mask bit, and wins
        // over a clear of the same line on the same edge.
        state_d.mask = ((state_q.mask | set_m) & ~clr_m) | auto_set;
        state_d.sw   = (state_q.sw | set_s) & ~clr_s;
        if (cfg_valid && !cfg_write) begin
            state_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mask  <= '1;
            state_q.sw    <= '0;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_q    = state_q.mask;
    assign sw_q      = state_q.sw;
    assign cfg_rdata = state_q.rdata;
endmodule

// File: rtl/irqc_event.sv
module irqc_event
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int HALF_W   = DATA_W / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_rd,
    input  logic [NUM_LINES-1:0] req_eff,
    output logic [NUM_LINES-1:0] auto_set,
    output logic [DATA_W-1:0]    evt_data,
    output logic                 irq_out
);
    typedef struct packed {
        logic [DATA_W-1:0] evt;
        logic              irq;
    } evt_state_t;

    evt_state_t state_d, state_q;

    logic             win_found;
    logic [IDX_W-1:0] win_idx;
    logic [DATA_W-1:0] win_word;

    irqc_prio_enc #(.NUM_LINES(NUM_LINES)) u_enc (
        .req   (req_eff),
        .found (win_found),
        .idx   (win_idx)
    );

    always_comb begin
        win_word = '0;
        win_word[HALF_W +: HALF_W] = HALF_W'(EVT_TYPE_HW);
        win_word[0 +: HALF_W]      = HALF_W'(win_idx);

        state_d     = state_q;
        state_d.irq = |req_eff;
        auto_set    = '0;
        if (evt_rd) begin
            if (win_found) begin
                state_d.evt       = win_word;
                auto_set[win_idx] = 1'b1;
            end else begin
                state_d.evt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.evt <= '0;
            state_q.irq <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign evt_data = state_q.evt;
    assign irq_out  = state_q.irq;
endmodule

// File: rtl/irq_arbiter_ctrl.sv
module irq_arbiter_ctrl #(
    parameter int NUM_LINES = 64,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_hw,
    input  logic                 cfg_valid,
    input  logic                 cfg_write,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 evt_rd,
    output logic [DATA_W-1:0]    evt_data,
    output logic                 irq_out
);
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] sw_q;
    logic [NUM_LINES-1:0] auto_set;
    logic [NUM_LINES-1:0] req_eff;

    assign req_eff = (irq_hw | sw_q) & ~mask_q;

    irqc_line_bank #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_write (cfg_write),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .auto_set  (auto_set),
        .mask_q    (mask_q),
        .sw_q      (sw_q),
        .cfg_rdata (cfg_rdata)
    );

    irqc_event #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_rd   (evt_rd),
        .req_eff  (req_eff),
        .auto_set (auto_set),
        .evt_data (evt_data),
        .irq_out  (irq_out)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int HALF_W   = DATA_W / 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_hw,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] sw_q,
    input logic                 cfg_valid,
    input logic                 cfg_write,
    input logic [REGION_W-1:0]  region,
    input logic                 evt_rd,
    input logic [DATA_W-1:0]    evt_data,
    input logic                 irq_out
);
    logic [NUM_LINES-1:0] eff;
    logic [NUM_LINES-1:0] prev_eff_q;
    logic                 prev_rd_q;
    logic [IDX_W-1:0]     evt_idx;
    logic [NUM_LINES-1:0] below_mask;
    logic                 cfg_wr;

    assign eff        = (irq_hw | sw_q) & ~mask_q;
    assign evt_idx    = evt_data[IDX_W-1:0];
    assign below_mask = (NUM_LINES'(1) << evt_idx) - NUM_LINES'(1);
    assign cfg_wr     = cfg_valid && cfg_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_eff_q <= '0;
            prev_rd_q  <= 1'b0;
        end else begin
            prev_eff_q <= eff;
            prev_rd_q  <= evt_rd;
        end
    end

    assert_reset_state_R11: assert property (@(posedge clk)
        !rst_n |=> (&mask_q) && (sw_q == '0) && !irq_out && (evt_data == '0));

    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prev_rd_q && (evt_data != '0) |-> prev_eff_q[evt_idx] && ((prev_eff_q & below_mask) == '0));

    // R2: only an unmasked request can come out of the event port
    assert_empty_iff_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prev_rd_q |-> ((evt_data == '0) == (prev_eff_q == '0)));

    assert_event_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_data != '0) |-> (evt_data[DATA_W-1:HALF_W] == HALF_W'(EVT_TYPE_HW)));

    assert_auto_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (evt_data == '0) || mask_q[evt_idx]);

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == |prev_eff_q));

    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd && (eff == '0) && !cfg_wr |=> $stable(mask_q) && $stable(sw_q) && (evt_data == '0));

    // R10: mask bits drop only through a clear-mask write
    assert_mask_only_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && (region == RG_MCLR)) |=> (($past(mask_q) & ~mask_q) == '0));
endmodule

bind irq_arbiter_ctrl irqc_checker #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_hw    (irq_hw),
    .mask_q    (mask_q),
    .sw_q      (sw_q),
    .cfg_valid (cfg_valid),
    .cfg_write (cfg_write),
    .region    (cfg_addr[ADDR_W-1 -: 4]),
    .evt_rd    (evt_rd),
    .evt_data  (evt_data),
    .irq_out   (irq_out)
);

// File: tb/irq_arbiter_ctrl_tb.sv
module irq_arbiter_ctrl_tb;
    localparam int N  = 64;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [3:0] MSET = 4'd1, MCLR = 4'd2, SSET = 4'd3, SCLR = 4'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_hw = '0;
    logic          cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          evt_rd = 1'b0;
    logic [DW-1:0] evt_data;
    logic          irq_out;

    logic [N-1:0]  m_mask = '1;
    logic [N-1:0]  m_sw = '0;
    logic [DW-1:0] m_evt = '0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_arbiter_ctrl #(.NUM_LINES(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_hw(irq_hw),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .evt_rd(evt_rd), .evt_data(evt_data), .irq_out(irq_out)
    );

    function automatic logic [N-1:0] eff_of();
        return (irq_hw | m_sw) & ~m_mask;
    endfunction

    function automatic logic [DW-1:0] event_of(input logic [N-1:0] e);
        for (int i = 0; i < N; i++)
            if (e[i]) return {16'd1, 16'(i)};
        return '0;
    endfunction

    function automatic logic [DW-1:0] word_of(input logic [3:0] rg, input int w);
        if (w >= N / DW) return '0;
        if (rg == MSET || rg == MCLR) return m_mask[w*DW +: DW];
        if (rg == SSET || rg == SCLR) return m_sw[w*DW +: DW];
        return '0;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic apply_write(input logic [3:0] rg, input int w, input logic [DW-1:0] d);
        if (w < N / DW) begin
            case (rg)
                MSET: m_mask[w*DW +: DW] = m_mask[w*DW +: DW] | d;
                MCLR: m_mask[w*DW +: DW] = m_mask[w*DW +: DW] & ~d;
                SSET: m_sw[w*DW +: DW] = m_sw[w*DW +: DW] | d;
                SCLR: m_sw[w*DW +: DW] = m_sw[w*DW +: DW] & ~d;
                default: ;
            endcase
        end
    endtask

    task automatic do_write(input logic [3:0] rg, input int w, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = {rg, 4'(w)}; cfg_wdata = d;
        apply_write(rg, w, d);
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [3:0] rg, input int w);
        logic [DW-1:0] exp;
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = {rg, 4'(w)};
        exp = word_of(rg, w);
        @(negedge clk);
        cfg_valid = 1'b0;
        check(req, cfg_rdata, exp);
    endtask

    task automatic do_event(input string req);
        logic [N-1:0] e;
        @(negedge clk);
        evt_rd = 1'b1;
        e = eff_of();
        m_evt = event_of(e);
        if (m_evt != '0) m_mask[m_evt[5:0]] = 1'b1;
        @(negedge clk);
        evt_rd = 1'b0;
        check(req, evt_data, m_evt);
    endtask

    // State is stable here; one more rising edge brings irq_out up to date.
    task automatic check_irq(input string req);
        @(negedge clk);
        check(req, {31'd0, irq_out}, {31'd0, |eff_of()});
    endtask

    task automatic set_hw(input logic [N-1:0] v);
        @(negedge clk);
        irq_hw = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        irq_hw = '1;
        repeat (3) @(negedge clk);
        // R11: reset state visible before release
        check("R11 irq_out in reset", {31'd0, irq_out}, 32'd0);
        check("R11 evt_data in reset", evt_data, 32'd0);
        rst_n = 1'b1;
        do_read("R11 mask word0 all set", MSET, 0);
        do_read("R11 mask word1 all set", MCLR, 1);
        do_read("R11 trigger word0 clear", SSET, 0);
        check_irq("R2 all masked keeps irq low");
        do_event("R2 R8 masked lines not delivered");
        do_read("R8 masks unchanged after empty read", MSET, 1);

        // R1 R5 R6 R7: single hardware line 40
        set_hw('0);
        do_write(MCLR, 0, 32'h0000_0020);
        do_write(MCLR, 1, 32'h0000_0100);
        check_irq("R7 irq low with no request");
        set_hw(N'(1) << 40);
        check_irq("R7 irq high after input rises");
        do_event("R1 R5 line 40 delivered");
        check("R5 event encoding", evt_data, 32'h0001_0028);
        do_read("R6 mask bit 40 set by delivery", MSET, 1);
        check_irq("R7 irq low after auto-mask");
        repeat (3) @(negedge clk);
        check("R5 evt_data holds without read", evt_data, 32'h0001_0028);

        // R3 R6: software trigger on line 5
        set_hw('0);
        do_write(SSET, 0, 32'h0000_0020);
        check_irq("R3 trigger raises irq");
        do_event("R3 trigger alone delivered");
        do_read("R6 trigger bit kept after delivery", SCLR, 0);
        do_write(SCLR, 0, 32'h0000_0020);

        // R4: priority order 3, 7, 33
        do_write(MCLR, 0, 32'h0000_0088);
        do_write(MCLR, 1, 32'h0000_0002);
        do_write(SSET, 0, 32'h0000_0008);
        set_hw((N'(1) << 7) | (N'(1) << 33));
        do_event("R4 line 3 first");
        do_event("R4 line 7 second");
        do_event("R4 line 33 third");
        do_event("R8 nothing left");
        do_write(SCLR, 0, 32'h0000_0008);

        // R1: level dropped before the read
        do_write(MCLR, 0, 32'h0000_0400);
        set_hw(N'(1) << 10);
        set_hw('0);
        do_event("R1 dropped level not delivered");

        // R9: zero bits and unused addresses have no effect
        do_write(MSET, 0, 32'h0);
        do_read("R9 zero write leaves mask", MSET, 0);
        do_write(MCLR, 7, 32'hFFFF_FFFF);
        do_read("R9 unused word write ignored", MSET, 0);
        do_read("R9 unused region reads zero", 4'd9, 0);

        // R10: clear and auto-mask on the same edge
        do_write(MCLR, 0, 32'h0000_0204);
        set_hw((N'(1) << 2) | (N'(1) << 9));
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = {MCLR, 4'd0}; cfg_wdata = 32'h0000_1004;
        evt_rd = 1'b1;
        m_evt = event_of(eff_of());
        apply_write(MCLR, 0, 32'h0000_1004);
        m_mask[2] = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0; evt_rd = 1'b0;
        check("R10 line 2 delivered", evt_data, m_evt);
        do_read("R10 line 2 masked, line 12 cleared", MSET, 0);

        // Random phase
        for (int it = 0; it < 500; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: set_hw({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
                1: do_write(4'($urandom_range(1, 4)), int'($urandom_range(0, 2)),
                            $urandom & $urandom & $urandom);
                2: do_event("R4 R6 random event");
                3: check_irq("R7 random irq");
                4: do_read("R9 random read", 4'($urandom_range(0, 5)), int'($urandom_range(0, 2)));
                default: do_write(MCLR, int'($urandom_range(0, 1)), $urandom);
            endcase
        end
        check_irq("R7 final irq");
        finish_run();
    end
endmodule